// File: doc/BRIEF.md
# Byte-Wide Data Memory with Pointer Redirection

This block is the data store of a small 8-bit processor core. It holds 128 byte locations. The upper half, 40h to 7Fh, is general-purpose RAM. The lower half holds special locations: a 7-bit memory pointer, an accumulator and a set of placeholder registers that stand in for status, timer and port registers. The rest of the lower half is unimplemented and reads as zero. Address 00h has no storage of its own. Any access to it is carried out on the location named by the pointer. This lets the core walk through memory without changing the direct address.

A single access port carries an address, write data, a write enable, a bit-operation command and a 3-bit bit index. Read data is returned combinationally for the location addressed in the same cycle. A write or a bit operation takes effect at the next rising clock edge. A bit operation reads, modifies and writes back one byte within that single cycle. The accumulator value is also brought out on its own port, which an ALU would use. Reset is synchronous and active-low.

Top module: `datamem_core`

## Requirements
- R1: Addresses 40h to 7Fh form 64 bytes of RAM. `rdata` shows the addressed byte in the same cycle. A write with `wr_en` high is visible from the cycle after the clock edge.
- R2: An access to address 00h (read, write or bit operation) is carried out on the location whose address the pointer holds.
- R3: The pointer lives at address 01h and is 7 bits wide. A write stores only `wdata[6:0]`. A read returns the pointer in bits 6:0, with bit 7 always 1.
- R4: When the pointer holds 00h, a read of address 00h returns 00h. A write or bit operation on address 00h then changes no location.
- R5: The accumulator lives at address 05h and is read and written like any other location. Its current value is always driven on `acc`.
- R6: Addresses 02h to 0Fh, other than 05h, are placeholder registers that can be read and written. Addresses 10h to 3Fh read as 00h, and writes to them are ignored.
- R7: `bit_op` selects the operation: 2'b01 sets, 2'b10 clears, and 2'b00 or 2'b11 does nothing. A set or clear changes only bit `bit_sel` of the addressed byte, completes in one cycle and leaves the other seven bits unchanged.
- R8: When `bit_op` is a set or a clear, it takes priority over `wr_en`, and `wdata` is not stored.
- R9: A synchronous reset (`rst_n` low at a clock edge) clears the pointer, the accumulator and the placeholder registers. RAM contents are kept.
- R10: When the pointer holds 01h, an access to address 00h reaches the pointer itself, with the same 7-bit store and bit-7-reads-as-1 rules.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 7 | Direct location address |
| wr_en | input | 1 | Store `wdata` at the resolved location |
| wdata | input | 8 | Write data |
| bit_op | input | 2 | 01 set, 10 clear, 00/11 none |
| bit_sel | input | 3 | Bit index for set or clear |
| rdata | output | 8 | Read data for the resolved location, combinational |
| acc | output | 8 | Current accumulator value |

## Verification
Read data depends only on the current address and the stored state, so `rdata` is due in the cycle the address is applied. Any write, set or clear is due from the cycle after the rising edge that stores it. The bench changes its inputs on the falling edge and samples `rdata` and `acc` 1 ns later. Only after that sample does it apply the store to its reference model. Each compare therefore sees the state left by every earlier cycle and none of the current one. RAM bytes that have never been written are tracked as unknown and are not compared.

// File: rtl/dm_pkg.sv
// Package dm_pkg
// Shared types for the pointer-redirecting data memory.
// Assumes: a 2-bit bit-operation command on the access port.
package dm_pkg;

    // Bit-operation command codes; the two unused codes mean "no bit op"
    typedef enum logic [1:0] {
        BOP_NONE = 2'b00,
        BOP_SET  = 2'b01,
        BOP_CLR  = 2'b10,
        BOP_RSV  = 2'b11
    } bitop_e;

    // Region a resolved address falls into
    typedef enum logic [2:0] {
        RG_NULL,   // indirect through a zero pointer: no storage
        RG_PTR,    // the memory pointer itself
        RG_SPEC,   // accumulator and placeholder registers
        RG_HOLE,   // unimplemented, reads zero
        RG_RAM     // general-purpose RAM
    } region_e;

endpackage

// File: rtl/dm_resolve.sv
// Module dm_resolve
// Turns the direct address into an effective address (applying the
// pointer redirection of location 0) and classifies it into a region.
// Assumes: SPEC_LAST < RAM_BASE and the RAM region runs to the top.
module dm_resolve
    import dm_pkg::*;
#(
    parameter int AW        = 7,
    parameter int SPEC_LAST = 15,
    parameter int RAM_BASE  = 64
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] ptr,
    output logic [AW-1:0] eff_addr,
    output region_e       region
);
    localparam logic [AW-1:0] A_ZERO = '0;
    localparam logic [AW-1:0] A_PTR  = AW'(1);
    localparam logic [AW-1:0] A_SPEC = AW'(SPEC_LAST);
    localparam logic [AW-1:0] A_RAM  = AW'(RAM_BASE);

    // Redirect location 0 through the pointer
    always_comb begin
        eff_addr = (addr == A_ZERO) ? ptr : addr;
    end

    // Classify the effective address
    always_comb begin
        if (eff_addr == A_ZERO)
            region = RG_NULL;
        else if (eff_addr == A_PTR)
            region = RG_PTR;
        else if (eff_addr <= A_SPEC)
            region = RG_SPEC;
        else if (eff_addr >= A_RAM)
            region = RG_RAM;
        else
            region = RG_HOLE;
    end
endmodule

// File: rtl/dm_ptr_reg.sv
// Module dm_ptr_reg
// The memory pointer: an AW-bit register cleared by reset.
// Assumes: the caller has already truncated the write data to AW bits.
module dm_ptr_reg #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] d,
    output logic [AW-1:0] q
);
    // Pointer storage with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (we)
            q <= d;
    end

    // R3: a store lands exactly the low bits presented
    p_ptr_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q == $past(d)));

    // R3: the pointer holds its value when not written
    p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));
endmodule

// File: rtl/dm_spec_bank.sv
// Module dm_spec_bank
// The special-register bank: one byte register per address from
// SPEC_FIRST to SPEC_LAST, one of which is the accumulator.
// Assumes: SPEC_FIRST <= ACC_ADDR <= SPEC_LAST; waddr is decoded in full.
module dm_spec_bank #(
    parameter int AW         = 7,
    parameter int DW         = 8,
    parameter int SPEC_FIRST = 2,
    parameter int SPEC_LAST  = 15,
    parameter int ACC_ADDR   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] acc
);
    localparam int NREG    = SPEC_LAST - SPEC_FIRST + 1;
    localparam int ACC_IDX = ACC_ADDR - SPEC_FIRST;
    localparam logic [AW-1:0] A_ACC = AW'(ACC_ADDR);

    logic [DW-1:0] regs [NREG];

    // One register per special address
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [AW-1:0] A_MINE = AW'(SPEC_FIRST + g);
        // Store the byte when this address is written
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && addr == A_MINE)
                regs[g] <= wdata;
        end
    end

    // Read mux over the bank
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (addr == AW'(SPEC_FIRST + i))
                rdata = regs[i];
        end
    end

    assign acc = regs[ACC_IDX];

    // R5: the accumulator is stable unless addressed by a write
    p_acc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == A_ACC) |=> $stable(acc));

    // R5: an accumulator write shows on the acc port next cycle
    p_acc_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_ACC) |=> (acc == $past(wdata)));
endmodule

// File: rtl/dm_gp_ram.sv
// Module dm_gp_ram
// General-purpose RAM: DEPTH bytes, one write and one asynchronous
// read index. Contents are not reset.
// Assumes: the index is already relative to the RAM base address.
module dm_gp_ram #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Byte store, no reset by design
    always_ff @(posedge clk) begin
        if (we)
            mem[idx] <= wdata;
    end

    assign rdata = mem[idx];

    // R1: a stored byte reads back on the following cycle
    p_ram_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(idx)] == $past(wdata)));
endmodule

// File: rtl/datamem_core.sv
// Module datamem_core
// Top of the data memory: resolves location 0 through the pointer,
// returns read data combinationally and performs writes and
// single-cycle bit set/clear read-modify-writes at the clock edge.
// Assumes: DW > AW (the pointer's unused upper bits read as 1),
// SPEC_LAST < RAM_BASE, and synchronous active-low reset.
module datamem_core
    import dm_pkg::*;
#(
    parameter int AW        = 7,
    parameter int DW        = 8,
    parameter int SPEC_LAST = 15,
    parameter int RAM_BASE  = 64,
    parameter int ACC_ADDR  = 5,
    parameter int BW        = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic [1:0]    bit_op,
    input  logic [BW-1:0] bit_sel,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] acc
);
    localparam int RAM_DEPTH = (1 << AW) - RAM_BASE;
    localparam int RIW       = $clog2(RAM_DEPTH);
    localparam logic [AW-1:0] A_RAM  = AW'(RAM_BASE);
    localparam logic [AW-1:0] A_HOLE = AW'(SPEC_LAST + 1);
    localparam logic [AW-1:0] A_ACC  = AW'(ACC_ADDR);

    logic [AW-1:0]  ptr_q;
    logic [AW-1:0]  eff_addr;
    region_e        region;
    logic [DW-1:0]  ptr_rd, spec_rd, ram_rd, cur, new_val;
    logic [RIW-1:0] ram_idx;
    logic           is_bop, do_wr;
    bitop_e         bop;

    assign bop = bitop_e'(bit_op);

    dm_resolve #(.AW(AW), .SPEC_LAST(SPEC_LAST), .RAM_BASE(RAM_BASE)) u_resolve (
        .addr     (addr),
        .ptr      (ptr_q),
        .eff_addr (eff_addr),
        .region   (region)
    );

    dm_ptr_reg #(.AW(AW)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (do_wr && region == RG_PTR),
        .d     (new_val[AW-1:0]),
        .q     (ptr_q)
    );

    dm_spec_bank #(.AW(AW), .DW(DW), .SPEC_FIRST(2), .SPEC_LAST(SPEC_LAST),
                   .ACC_ADDR(ACC_ADDR)) u_spec (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (do_wr && region == RG_SPEC),
        .addr  (eff_addr),
        .wdata (new_val),
        .rdata (spec_rd),
        .acc   (acc)
    );

    assign ram_idx = RIW'(eff_addr - A_RAM);

    dm_gp_ram #(.DW(DW), .DEPTH(RAM_DEPTH), .IW(RIW)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (do_wr && region == RG_RAM),
        .idx   (ram_idx),
        .wdata (new_val),
        .rdata (ram_rd)
    );

    // Pointer read view: unused upper bits read as 1
    always_comb begin
        ptr_rd = '1;
        ptr_rd[AW-1:0] = ptr_q;
    end

    // Read mux by region of the effective address
    always_comb begin
        case (region)
            RG_PTR:  cur = ptr_rd;
            RG_SPEC: cur = spec_rd;
            RG_RAM:  cur = ram_rd;
            default: cur = '0;
        endcase
    end

    assign rdata = cur;

    // Next value: bit set/clear on the current byte, else write data
    always_comb begin
        is_bop  = (bop == BOP_SET) || (bop == BOP_CLR);
        do_wr   = is_bop || wr_en;
        new_val = is_bop ? cur : wdata;
        if (is_bop)
            new_val[bit_sel] = (bop == BOP_SET);
    end

    // R3: bit 7 of the pointer location reads as one
    p_ptr_bit7_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == AW'(1)) |-> rdata[DW-1]);

    // R4: indirect read through a zero pointer returns zero
    p_null_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == '0 && ptr_q == '0) |-> (rdata == '0));

    // R4: indirect store through a zero pointer leaves pointer and acc
    p_null_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == '0 && ptr_q == '0) |=> ($stable(ptr_q) && $stable(acc)));

    // R6: unimplemented addresses read zero
    p_hole_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= A_HOLE && addr < A_RAM) |-> (rdata == '0));

    // R8: a set on the accumulator wins over a plain write
    p_bitop_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_ACC && bop == BOP_SET) |=> acc[$past(bit_sel)]);

    // R7: a clear on the accumulator drops only the selected bit
    p_bitclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_ACC && bop == BOP_CLR) |=>
            (acc == ($past(acc) & ~(DW'(1) << $past(bit_sel)))));
endmodule

// File: tb/test_datamem_core.sv
`timescale 1ns/1ps
module test_datamem_core;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [6:0] addr;
    logic       wr_en;
    logic [7:0] wdata;
    logic [1:0] bit_op;
    logic [2:0] bit_sel;
    logic [7:0] rdata;
    logic [7:0] acc;

    int errs = 0;
    int checks = 0;
    int mref [128];
    bit known [128];
    int mp_m = 0;

    always #2 clk = ~clk;

    datamem_core i_datamem_core (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .bit_op(bit_op), .bit_sel(bit_sel), .rdata(rdata), .acc(acc)
    );

    function automatic int m_eff(int a);
        return (a == 0) ? mp_m : a;
    endfunction

    function automatic bit m_known(int a);
        int ea = m_eff(a);
        return (ea >= 64) ? known[ea] : 1'b1;
    endfunction

    function automatic int m_rd(int a);
        int ea = m_eff(a);
        if (ea == 0) return 0;
        if (ea == 1) return 128 | mp_m;
        if (ea <= 15) return mref[ea];
        if (ea < 64) return 0;
        return mref[ea];
    endfunction

    function automatic void m_wr(int a, int v, bit kn);
        int ea = m_eff(a);
        if (ea == 0) return;
        if (ea == 1) mp_m = v & 127;
        else if (ea <= 15) mref[ea] = v & 255;
        else if (ea >= 64) begin
            mref[ea] = v & 255;
            known[ea] = kn;
        end
    endfunction

    task automatic check(int got, int exp, string tag);
        checks++;
        if (got != exp) begin
            errs++;
            $display("FAIL %s got %02h exp %02h", tag, got, exp);
        end
    endtask

    // One cycle: drive at falling edge, compare, then advance the model
    task automatic step(int a, bit we, int wd, int op, int bs, string tag);
        bit kn;
        int v;
        @(negedge clk);
        addr = 7'(a); wr_en = we; wdata = 8'(wd); bit_op = 2'(op); bit_sel = 3'(bs);
        #1;
        if (m_known(a)) check(int'(rdata), m_rd(a), tag);
        check(int'(acc), mref[5], "R5 acc port");
        if (op == 1 || op == 2) begin
            kn = m_known(a);
            v = m_rd(a);
            if (op == 1) v = v | (1 << bs);
            else v = v & ~(1 << bs);
            m_wr(a, v, kn);
        end else if (we) begin
            m_wr(a, wd, 1'b1);
        end
    endtask

    task automatic rd(int a, string tag);
        step(a, 1'b0, 0, 0, 0, tag);
    endtask

    task automatic wr(int a, int d);
        step(a, 1'b1, d, 0, 0, "R1 wr");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; bit_op = 2'b00;
        @(posedge clk);
        @(posedge clk);
        mp_m = 0;
        for (int i = 2; i <= 15; i++) mref[i] = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        errs++;
        $display("FAIL watchdog R1 got timeout exp completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) begin mref[i] = 0; known[i] = 1'b0; end
        rst_n = 1'b0; addr = '0; wr_en = 1'b0; wdata = '0; bit_op = '0; bit_sel = '0;
        do_reset();
        // R9: reset state
        rd(1, "R9 ptr reset");
        rd(5, "R9 acc reset");
        rd(3, "R9 placeholder reset");
        // R1: RAM at both ends
        wr(7'h40, 8'h3C); wr(7'h7F, 8'hC3);
        rd(7'h40, "R1 ram low"); rd(7'h7F, "R1 ram high");
        // R5: accumulator
        wr(5, 8'h99); rd(5, "R5 acc read");
        // R3: pointer width and bit 7
        wr(1, 8'hFF); rd(1, "R3 ptr all ones");
        wr(1, 8'h45); rd(1, "R3 ptr truncate");
        // R2: indirect write and read
        wr(1, 8'h41); wr(0, 8'h5A);
        rd(7'h41, "R2 indirect write"); rd(0, "R2 indirect read");
        // R10: pointer names itself
        wr(1, 8'h01); rd(0, "R10 self read");
        wr(0, 8'h85); rd(1, "R10 self write"); rd(0, "R10 now acc");
        // R4: zero pointer
        wr(1, 8'h00); wr(0, 8'h77);
        rd(0, "R4 null read"); rd(1, "R4 ptr unchanged"); rd(5, "R4 acc unchanged");
        step(0, 1'b0, 0, 1, 3, "R4 null bitset"); rd(1, "R4 after bitset");
        // R6: holes and placeholders
        wr(7'h20, 8'hFF); rd(7'h20, "R6 hole read");
        wr(7'h10, 8'hAA); rd(7'h10, "R6 hole low edge");
        wr(3, 8'h11); rd(3, "R6 placeholder");
        wr(7'h0F, 8'h22); rd(7'h0F, "R6 last placeholder");
        // R7: bit set / clear, direct and indirect
        step(7'h40, 1'b0, 0, 1, 7, "R7 set"); rd(7'h40, "R7 after set");
        step(7'h40, 1'b0, 0, 2, 2, "R7 clr"); rd(7'h40, "R7 after clr");
        wr(1, 8'h40);
        step(0, 1'b0, 0, 1, 0, "R7 indirect set"); rd(7'h40, "R7 indirect result");
        step(1, 1'b0, 0, 2, 7, "R7 clr ptr bit7"); rd(1, "R7 ptr bit7 still 1");
        step(5, 1'b1, 8'hFF, 3, 1, "R7 reserved code writes"); rd(5, "R7 reserved result");
        // R8: bit op wins over write
        step(5, 1'b1, 8'h00, 2, 4, "R8 clr with wr"); rd(5, "R8 clr result");
        step(5, 1'b1, 8'h00, 1, 6, "R8 set with wr"); rd(5, "R8 set result");
        // R9: mid-run reset keeps RAM
        wr(7'h55, 8'hA5);
        do_reset();
        rd(7'h55, "R9 ram kept"); rd(5, "R9 acc cleared"); rd(1, "R9 ptr cleared");
        rd(3, "R9 placeholder cleared");
        // Random mix against the reference model
        for (int n = 0; n < 4000; n++) begin
            int sel = int'($urandom % 8);
            int a;
            case (sel)
                0: a = 0;
                1: a = 1;
                2: a = 5;
                3: a = 2 + int'($urandom % 14);
                4: a = 16 + int'($urandom % 48);
                default: a = 64 + int'($urandom % 64);
            endcase
            step(a, 1'($urandom % 2), int'($urandom % 256), int'($urandom % 4),
                 int'($urandom % 8), "R2 random mix");
        end
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule